// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Nesting

This block serves one processor interface of an interrupt controller. Each cycle it looks at every source that is both enabled and pending and picks the most urgent one. Urgency comes from an 8-bit priority per source, where a smaller number means more urgent. It registers that choice and raises an interrupt request when the chosen source would preempt whatever is currently being serviced.

When the processor acknowledges, the chosen ID becomes the running interrupt. The arbiter returns that ID and pulses a clear strobe toward the pending latch of that source. It also records the interrupt that was running before, in a table indexed by the new ID. An end-of-interrupt for the running ID puts that recorded predecessor back as running, so nested handlers unwind in order.

The reserved ID 1023 stands for "nothing": no qualifying source, no running interrupt, or a denied acknowledge.

Top module: `irq_arb_top`

## Requirements
- R1: Only sources with both their pending bit and their enable bit at 1 take part in selection. When no source qualifies, the selected ID is 1023.
- R2: Among qualifying sources, the one with the numerically smallest priority value is selected. The selection is registered, so `sel_id_o` reflects the inputs sampled at the previous rising edge.
- R3: When qualifying sources share the smallest priority value, the lowest ID among them is selected.
- R4: `irq_o` is 1 exactly when the selected ID is not 1023 and the selected priority is strictly smaller than the running interrupt's current priority. An idle interface (running ID 1023) counts as rank 0x100, above any 8-bit value.
- R5: An acknowledge while `irq_o` is 1 has three effects one cycle later. `ack_id_o` and `run_id_o` both equal the selected ID. `clr_pend_o` has only the bit at that ID set, for exactly one cycle. The previously running ID is recorded as the new interrupt's predecessor.
- R6: An acknowledge while `irq_o` is 0 sets `ack_id_o` to 1023. It leaves `run_id_o` unchanged and raises no clear bit.
- R7: An end-of-interrupt whose ID equals the running ID makes the recorded predecessor of that ID the running ID, one cycle later.
- R8: An end-of-interrupt has no effect while the running ID is 1023.
- R9: An end-of-interrupt for a valid ID that is not running leaves `run_id_o` unchanged. Any interrupt whose recorded predecessor is that ID takes over that ID's own predecessor.
- R10: After reset, the outputs are: `sel_id_o`, `run_id_o` and `ack_id_o` at 1023, `irq_o` at 0, and `clr_pend_o` all zero. Every predecessor entry reads 1023.
- R11: When an acknowledge and an end-of-interrupt arrive in the same cycle, the acknowledge is processed and the end-of-interrupt is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_SRC | Effective pending state per source |
| en_i | input | NUM_SRC | Enable per source |
| prio_i | input | NUM_SRC*8 | Priority per source, source k in bits [8k+7:8k] |
| ack_req_i | input | 1 | Acknowledge request |
| eoi_req_i | input | 1 | End-of-interrupt request |
| eoi_id_i | input | 10 | ID being completed |
| sel_id_o | output | 10 | Registered selected ID, 1023 when none |
| irq_o | output | 1 | Interrupt request toward the processor |
| run_id_o | output | 10 | Running interrupt ID, 1023 when idle |
| ack_id_o | output | 10 | ID returned by the latest acknowledge |
| clr_pend_o | output | NUM_SRC | One-cycle pending clear pulse on acknowledge |

## Verification
The bench builds the block with NUM_SRC = 8. This puts both end IDs, 0 and 7, within easy reach for the tie-break and boundary cases. It also lets a three-deep nesting chain and a mid-chain completion be built in a few dozen cycles. Priorities span the full 8-bit range, including 0x00 and 0xFF against the idle rank of 0x100.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int RANK_W = PRIO_W + 1;

  typedef logic [ID_W-1:0]   irq_id_t;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [RANK_W-1:0] rank_t;

  localparam irq_id_t SPUR_ID   = irq_id_t'(1023);
  localparam rank_t   RANK_NONE = rank_t'(9'h100);
endpackage

// File: rtl/irq_arb_select.sv
module irq_arb_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output irq_id_t                   sel_id_o,
  output rank_t                     sel_rank_o
);
  logic [NUM_SRC-1:0] cand;
  prio_t              prio_a [NUM_SRC];
  irq_id_t            best_id_d;
  rank_t              best_rank_d;
  irq_id_t            sel_id_q;
  rank_t              sel_rank_q;
  logic               sel_en;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_unpack
      assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
      assign cand[g]   = pend_i[g] & en_i[g];
    end
  endgenerate

  // Single linear pass; strict compare keeps the lowest ID on a tie.
  always_comb begin
    best_id_d   = SPUR_ID;
    best_rank_d = RANK_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && ({1'b0, prio_a[i]} < best_rank_d)) begin
        best_rank_d = {1'b0, prio_a[i]};
        best_id_d   = irq_id_t'(i);
      end
    end
  end

  assign sel_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_id_q   <= SPUR_ID;
      sel_rank_q <= RANK_NONE;
    end else if (sel_en) begin
      sel_id_q   <= best_id_d;
      sel_rank_q <= best_rank_d;
    end
  end

  assign sel_id_o   = sel_id_q;
  assign sel_rank_o = sel_rank_q;

  // Assertion support: decode the registered choice.
  logic [NUM_SRC-1:0] sel_hit;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_hit
      assign sel_hit[g] = (sel_id_q == irq_id_t'(g));
    end
  endgenerate

  AST_SEL_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_id_q != SPUR_ID) |-> |($past(cand) & sel_hit)); // R1
  AST_SEL_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cand) == '0) |-> (sel_id_q == SPUR_ID)); // R1
endmodule

// File: rtl/irq_arb_nest.sv
module irq_arb_nest
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_req_i,
  input  logic               eoi_req_i,
  input  irq_id_t            eoi_id_i,
  input  irq_id_t            sel_id_i,
  input  logic               grant_i,
  output irq_id_t            run_id_o,
  output irq_id_t            ack_id_o,
  output logic [NUM_SRC-1:0] clr_pend_o
);
  localparam int      IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam irq_id_t N_ID  = irq_id_t'(NUM_SRC);

  irq_id_t            run_q, run_d;
  irq_id_t            ack_q, ack_d;
  logic [NUM_SRC-1:0] clr_q, clr_d;
  irq_id_t            pred_q [NUM_SRC];
  irq_id_t            pred_d [NUM_SRC];
  logic [NUM_SRC-1:0] pred_we;
  logic [IDX_W-1:0]   sel_idx, run_idx, eoi_idx;
  logic               take_ack, take_eoi, eoi_is_run, eoi_valid;

  assign sel_idx    = sel_id_i[IDX_W-1:0];
  assign run_idx    = run_q[IDX_W-1:0];
  assign eoi_idx    = eoi_id_i[IDX_W-1:0];
  assign take_ack   = ack_req_i;
  assign take_eoi   = !ack_req_i && eoi_req_i && (run_q != SPUR_ID);
  assign eoi_is_run = (eoi_id_i == run_q);
  assign eoi_valid  = (eoi_id_i < N_ID);

  always_comb begin
    run_d   = run_q;
    ack_d   = ack_q;
    clr_d   = '0;
    pred_we = '0;
    for (int i = 0; i < NUM_SRC; i++) pred_d[i] = pred_q[i];

    if (take_ack) begin
      if (grant_i) begin
        ack_d            = sel_id_i;
        run_d            = sel_id_i;
        pred_d[sel_idx]  = run_q;
        pred_we[sel_idx] = 1'b1;
        clr_d[sel_idx]   = 1'b1;
      end else begin
        ack_d = SPUR_ID;
      end
    end else if (take_eoi) begin
      if (eoi_is_run) begin
        run_d = pred_q[run_idx];
      end else if (eoi_valid) begin
        // Unlink a completed interrupt from the middle of the chain.
        for (int i = 0; i < NUM_SRC; i++) begin
          if (pred_q[i] == eoi_id_i) begin
            pred_d[i]  = pred_q[eoi_idx];
            pred_we[i] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= SPUR_ID;
      ack_q <= SPUR_ID;
      clr_q <= '0;
    end else begin
      run_q <= run_d;
      ack_q <= ack_d;
      clr_q <= clr_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_pred
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pred_q[g] <= SPUR_ID;
        end else if (pred_we[g]) begin
          pred_q[g] <= pred_d[g];
        end
      end
    end
  endgenerate

  assign run_id_o   = run_q;
  assign ack_id_o   = ack_q;
  assign clr_pend_o = clr_q;

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_pend_o)); // R5
  AST_ACK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_i && grant_i) |=> (run_id_o == $past(sel_id_i)) && (ack_id_o == run_id_o)); // R5
  AST_ACK_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_i && !grant_i) |=> (ack_id_o == SPUR_ID) && $stable(run_id_o) && (clr_pend_o == '0)); // R6
  AST_EOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_req_i && eoi_req_i && (run_id_o == SPUR_ID)) |=> (run_id_o == SPUR_ID)); // R8
  AST_EOI_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_req_i && eoi_req_i && (eoi_id_i != run_id_o)) |=> $stable(run_id_o)); // R9
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic                      ack_req_i,
  input  logic                      eoi_req_i,
  input  logic [ID_W-1:0]           eoi_id_i,
  output logic [ID_W-1:0]           sel_id_o,
  output logic                      irq_o,
  output logic [ID_W-1:0]           run_id_o,
  output logic [ID_W-1:0]           ack_id_o,
  output logic [NUM_SRC-1:0]        clr_pend_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  irq_id_t          sel_id;
  rank_t            sel_rank;
  irq_id_t          run_id;
  rank_t            run_rank;
  logic [IDX_W-1:0] run_idx;
  logic             grant;

  irq_arb_select #(.NUM_SRC(NUM_SRC)) u_select (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend_i),
    .en_i       (en_i),
    .prio_i     (prio_i),
    .sel_id_o   (sel_id),
    .sel_rank_o (sel_rank)
  );

  // Running rank follows the live priority input of the running source.
  assign run_idx = run_id[IDX_W-1:0];
  always_comb begin
    if (run_id == SPUR_ID) run_rank = RANK_NONE;
    else                   run_rank = {1'b0, prio_i[run_idx*PRIO_W +: PRIO_W]};
  end

  assign grant = (sel_id != SPUR_ID) && (sel_rank < run_rank);

  irq_arb_nest #(.NUM_SRC(NUM_SRC)) u_nest (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_req_i  (ack_req_i),
    .eoi_req_i  (eoi_req_i),
    .eoi_id_i   (eoi_id_i),
    .sel_id_i   (sel_id),
    .grant_i    (grant),
    .run_id_o   (run_id),
    .ack_id_o   (ack_id_o),
    .clr_pend_o (clr_pend_o)
  );

  assign sel_id_o = sel_id;
  assign run_id_o = run_id;
  assign irq_o    = grant;

  AST_IRQ_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sel_id_o != SPUR_ID) && (run_id_o != sel_id_o)); // R4
endmodule

// File: tb/irq_arb_top_bench.sv
module irq_arb_top_bench;
  localparam int N = 8;
  localparam int SP = 1023;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    pend_i, en_i;
  logic [N*8-1:0]  prio_i;
  logic            ack_req_i, eoi_req_i;
  logic [9:0]      eoi_id_i;
  logic [9:0]      sel_id_o, run_id_o, ack_id_o;
  logic            irq_o;
  logic [N-1:0]    clr_pend_o;

  irq_arb_top #(.NUM_SRC(N)) u_irq_arb_top (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .prio_i(prio_i),
    .ack_req_i(ack_req_i), .eoi_req_i(eoi_req_i), .eoi_id_i(eoi_id_i),
    .sel_id_o(sel_id_o), .irq_o(irq_o), .run_id_o(run_id_o),
    .ack_id_o(ack_id_o), .clr_pend_o(clr_pend_o)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    int           due;
    logic [9:0]   sel;
    logic         irq;
    logic [9:0]   run;
    logic [9:0]   ack;
    logic [N-1:0] clr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0, cyc = 0;
  bit    done = 0;

  // Reference model state
  logic [N-1:0] m_pend, m_en;
  logic [7:0]   m_prio [N];
  int           m_sel = SP, m_sel_rank = 256, m_run = SP, m_ack = SP;
  int           m_pred [N];

  function automatic int rank_of_run(int id);
    return (id == SP) ? 256 : int'(m_prio[id]);
  endfunction

  task automatic check(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic step(string tag, logic ack, logic eoi, int eid);
    exp_t e;
    logic [N-1:0] clr;
    bit cur_irq;
    @(negedge clk);
    pend_i = m_pend;
    en_i   = m_en;
    for (int i = 0; i < N; i++) prio_i[i*8 +: 8] = m_prio[i];
    ack_req_i = ack;
    eoi_req_i = eoi;
    eoi_id_i  = 10'(eid);
    cur_irq = (m_sel != SP) && (m_sel_rank < rank_of_run(m_run));
    clr = '0;
    if (ack) begin
      if (cur_irq) begin
        m_pred[m_sel] = m_run;
        m_run = m_sel;
        m_ack = m_sel;
        clr[m_sel] = 1'b1;
      end else begin
        m_ack = SP;
      end
    end else if (eoi && m_run != SP) begin
      if (eid == m_run) m_run = m_pred[m_run];
      else if (eid < N) begin
        for (int i = 0; i < N; i++)
          if (m_pred[i] == eid) m_pred[i] = m_pred[eid];
      end
    end
    m_sel = SP;
    m_sel_rank = 256;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && int'(m_prio[i]) < m_sel_rank) begin
        m_sel = i;
        m_sel_rank = int'(m_prio[i]);
      end
    e.due = cyc + 1;
    e.sel = 10'(m_sel);
    e.irq = (m_sel != SP) && (m_sel_rank < rank_of_run(m_run));
    e.run = 10'(m_run);
    e.ack = 10'(m_ack);
    e.clr = clr;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare after each rising edge.
  initial begin
    forever begin
      exp_t  e;
      string t;
      @(posedge clk);
      #2;
      cyc++;
      while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "sel_id", int'(sel_id_o), int'(e.sel));
        check(t, "irq", int'(irq_o), int'(e.irq));
        check(t, "run_id", int'(run_id_o), int'(e.run));
        check(t, "ack_id", int'(ack_id_o), int'(e.ack));
        check(t, "clr_pend", int'(clr_pend_o), int'(e.clr));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    m_pend = '0; m_en = '0;
    for (int i = 0; i < N; i++) begin m_prio[i] = 8'hFF; m_pred[i] = SP; end
    pend_i = '0; en_i = '0; prio_i = '1;
    ack_req_i = 0; eoi_req_i = 0; eoi_id_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", "sel_id", int'(sel_id_o), SP);
    check("R10", "irq", int'(irq_o), 0);
    check("R10", "run_id", int'(run_id_o), SP);
    check("R10", "ack_id", int'(ack_id_o), SP);
    check("R10", "clr_pend", int'(clr_pend_o), 0);

    step("R1_idle", 0, 0, 0);
    m_pend[3] = 1; m_prio[3] = 8'h40;
    step("R1_not_enabled", 0, 0, 0);
    m_en[3] = 1;
    step("R2_single", 0, 0, 0);
    m_pend[5] = 1; m_en[5] = 1; m_prio[5] = 8'h10;
    step("R2_more_urgent", 0, 0, 0);
    m_prio[3] = 8'h10;
    step("R3_tie_low_id", 0, 0, 0);
    m_pend[0] = 1; m_en[0] = 1; m_prio[0] = 8'h05;
    m_pend[7] = 1; m_en[7] = 1; m_prio[7] = 8'h05;
    step("R3_tie_ends", 0, 0, 0);
    m_pend[0] = 0; m_pend[7] = 0;
    step("R2_back", 0, 0, 0);
    step("R5_ack_first", 1, 0, 0);
    m_pend[3] = 0;
    step("R4_equal_no_irq", 0, 0, 0);
    step("R6_ack_denied", 1, 0, 0);
    m_prio[5] = 8'h08;
    step("R4_preempt", 0, 0, 0);
    step("R5_ack_nested", 1, 0, 0);
    m_pend[5] = 0;
    step("R5_pulse_drops", 0, 0, 0);
    step("R7_eoi_inner", 0, 1, 5);
    step("R7_eoi_outer", 0, 1, 3);
    step("R8_eoi_idle", 0, 1, 2);
    step("R8_eoi_idle_run", 0, 1, 1023);

    // Three-deep chain, then complete the bottom one out of order.
    m_pend[2] = 1; m_en[2] = 1; m_prio[2] = 8'h40;
    step("R9_setup_a", 0, 0, 0);
    step("R9_ack_a", 1, 0, 0);
    m_pend[2] = 0; m_pend[6] = 1; m_en[6] = 1; m_prio[6] = 8'h20;
    step("R9_setup_b", 0, 0, 0);
    step("R9_ack_b", 1, 0, 0);
    m_pend[6] = 0; m_pend[1] = 1; m_en[1] = 1; m_prio[1] = 8'h00;
    step("R9_setup_c", 0, 0, 0);
    step("R9_ack_c", 1, 0, 0);
    m_pend[1] = 0;
    step("R9_settle", 0, 0, 0);
    step("R9_eoi_not_running", 0, 1, 2);
    step("R9_eoi_top", 0, 1, 1);
    step("R9_eoi_unlinked", 0, 1, 6);
    step("R8_after_chain", 0, 1, 6);

    // Simultaneous acknowledge and completion.
    m_pend[4] = 1; m_en[4] = 1; m_prio[4] = 8'h30;
    step("R11_setup", 0, 0, 0);
    step("R11_ack", 1, 0, 0);
    m_pend[4] = 0; m_pend[7] = 1; m_prio[7] = 8'h01;
    step("R11_setup2", 0, 0, 0);
    step("R11_both", 1, 1, 4);
    m_pend[7] = 0;
    step("R11_eoi_top", 0, 1, 7);
    step("R11_eoi_last", 0, 1, 4);

    // Lowest urgency still beats an idle interface.
    m_pend[6] = 1; m_prio[6] = 8'hFF;
    step("R4_ff_vs_idle", 0, 0, 0);
    step("R5_ack_ff", 1, 0, 0);
    m_pend[6] = 0;
    step("R4_after_ff", 0, 0, 0);
    step("R7_eoi_ff", 0, 1, 6);
    step("R1_final_idle", 0, 0, 0);

    repeat (4) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule